// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control unit of a small accumulator computer. A counter of timing steps moves every instruction through the same sequence. It fetches the instruction word addressed by the program counter into the instruction register. It then decodes the word. Where the word asks for it, the block resolves an indirect operand address. Last, it executes the operation against a synchronous single-port memory. The block owns the program counter, the address register, the instruction register, a data register and the accumulator.

An instruction word is 16 bits. Bit 15 selects the addressing mode, where 1 means indirect. Bits 14:12 hold the opcode and bits 11:0 hold the address field. Memory-reference instructions take five clock cycles whether they use direct or indirect addressing. Register-type instructions (opcode 7) finish in four cycles.

The block drives the memory address from the value the address register is being loaded with. The memory registers that address on the same clock edge and returns its word one cycle later.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is high, and on the cycle after it falls, pc, ar, ir and ac read zero and mem_we is low. The first instruction is fetched from address 0.
- R2: The first fetch cycle (T0) copies pc into ar. The next cycle (T1) loads ir with the memory word at that address and increments pc by one, modulo 4096.
- R3: For a memory-reference instruction with bit 15 clear, T2 loads ar with bits 11:0 of ir. T3 leaves ar unchanged, and the operation executes at T4. The instruction takes 5 cycles.
- R4: For a memory-reference instruction with bit 15 set, T3 loads ar with bits 11:0 of the memory word at the address field. Execution then uses that word as the effective address, and the instruction still takes 5 cycles.
- R5: At T4, opcode 0 sets ac to ac AND M[EA], opcode 1 sets ac to ac + M[EA] modulo 2^16, and opcode 2 sets ac to M[EA].
- R6: Opcode 3 writes ac to M[EA]. mem_we is high for exactly that one T4 cycle, with mem_addr = EA and mem_wdata = ac. mem_we is never high at any other time.
- R7: Opcode 4 loads pc with EA at T4.
- R8: Opcode 7 completes at T3 in 4 cycles with no memory write, and bit 15 is ignored. Bit 3 clears ac, then bit 2 complements it, then bit 1 adds one. Each of these applies only when its bit is set.
- R9: Opcode 7 with bit 0 set halts the sequencer after that instruction's accumulator update. From then until reset, pc, ar, ir and ac hold their values and mem_we stays low.
- R10: Opcodes 5 and 6 run the normal 5-cycle sequence, including any indirect step, and leave ac and pc unchanged apart from the fetch increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Memory word for the address presented one cycle earlier |
| mem_addr | output | 12 | Memory address, the value being loaded into ar |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| ar_o | output | 12 | Address register |
| ac_o | output | 16 | Accumulator |

## Verification
The bench builds the block with its default widths: a 12-bit address field, a 3-bit opcode and 16-bit words. With these widths the full 4096-word memory is addressable. At 16 bits an ADD can carry out of the top bit, and the program forces that wrap on purpose. At these sizes a program that touches every opcode, both addressing modes, stores followed by indirect loads, both branch kinds and a halt runs twice in a few hundred cycles. The second run starts from a reset applied while the block is halted.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    parameter int unsigned ADDR_W = 12;
    parameter int unsigned OPC_W  = 3;
    localparam int unsigned WORD_W   = 1 + OPC_W + ADDR_W;
    localparam int unsigned MODE_BIT = WORD_W - 1;
    localparam int unsigned OPC_LSB  = ADDR_W;

    // register-type operation select bits inside the address field
    localparam int unsigned RB_HALT = 0;
    localparam int unsigned RB_INC  = 1;
    localparam int unsigned RB_CMP  = 2;
    localparam int unsigned RB_CLR  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OPC_W-1:0] {
        OP_AND  = 3'd0,
        OP_ADD  = 3'd1,
        OP_LDA  = 3'd2,
        OP_STA  = 3'd3,
        OP_BUN  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_REG  = 3'd7
    } opc_e;

    typedef enum logic [2:0] {
        ST_T0 = 3'd0,
        ST_T1 = 3'd1,
        ST_T2 = 3'd2,
        ST_T3 = 3'd3,
        ST_T4 = 3'd4
    } step_e;

    typedef struct packed {
        logic  indirect;
        opc_e  opc;
        addr_t addr;
        logic  is_reg;
        logic  r_clr;
        logic  r_cmp;
        logic  r_inc;
        logic  r_halt;
    } dec_t;

    typedef struct packed {
        step_e step;
        logic  halted;
        addr_t pc;
        addr_t ar;
        word_t ir;
        word_t dr;
        word_t ac;
    } seq_t;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  word_t ir_i,
    output dec_t  dec_o
);

    opc_e opc_w;
    logic reg_w;

    always_comb begin
        opc_w = opc_e'(ir_i[OPC_LSB +: OPC_W]);
        reg_w = (opc_w == OP_REG);

        dec_o.indirect = ir_i[MODE_BIT];
        dec_o.opc      = opc_w;
        dec_o.addr     = ir_i[ADDR_W-1:0];
        dec_o.is_reg   = reg_w;
        dec_o.r_clr    = reg_w & ir_i[RB_CLR];
        dec_o.r_cmp    = reg_w & ir_i[RB_CMP];
        dec_o.r_inc    = reg_w & ir_i[RB_INC];
        dec_o.r_halt   = reg_w & ir_i[RB_HALT];
    end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
(
    input  dec_t  dec_i,
    input  word_t ac_i,
    input  word_t opnd_i,
    output word_t mem_res_o,
    output word_t reg_res_o
);

    word_t t_clr;
    word_t t_cmp;

    // memory-reference result
    always_comb begin
        unique case (dec_i.opc)
            OP_AND:  mem_res_o = ac_i & opnd_i;
            OP_ADD:  mem_res_o = ac_i + opnd_i;
            OP_LDA:  mem_res_o = opnd_i;
            default: mem_res_o = ac_i;
        endcase
    end

    // register-type chain: clear, complement, increment
    always_comb begin
        t_clr     = dec_i.r_clr ? '0 : ac_i;
        t_cmp     = dec_i.r_cmp ? ~t_clr : t_clr;
        reg_res_o = dec_i.r_inc ? t_cmp + 1'b1 : t_cmp;
    end

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] ir_o,
    output logic [ADDR_W-1:0] ar_o,
    output logic [WORD_W-1:0] ac_o
);

    localparam seq_t SEQ_RST = '{
        step:   ST_T0,
        halted: 1'b0,
        pc:     '0,
        ar:     '0,
        ir:     '0,
        dr:     '0,
        ac:     '0
    };

    seq_t  st_q;
    seq_t  st_d;
    logic  we_d;
    dec_t  dec;
    word_t mem_res;
    word_t reg_res;

    acc_seq_decode i_decode (
        .ir_i  (st_q.ir),
        .dec_o (dec)
    );

    acc_seq_alu i_alu (
        .dec_i     (dec),
        .ac_i      (st_q.ac),
        .opnd_i    (mem_rdata),
        .mem_res_o (mem_res),
        .reg_res_o (reg_res)
    );

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        if (!st_q.halted) begin
            unique case (st_q.step)
                ST_T0: begin
                    st_d.ar   = st_q.pc;
                    st_d.step = ST_T1;
                end
                ST_T1: begin
                    st_d.ir   = mem_rdata;
                    st_d.dr   = mem_rdata;
                    st_d.pc   = st_q.pc + 1'b1;
                    st_d.step = ST_T2;
                end
                ST_T2: begin
                    if (!dec.is_reg) begin
                        st_d.ar = dec.addr;
                    end
                    st_d.step = ST_T3;
                end
                ST_T3: begin
                    if (dec.is_reg) begin
                        st_d.ac     = reg_res;
                        st_d.halted = dec.r_halt;
                        st_d.step   = ST_T0;
                    end else begin
                        if (dec.indirect) begin
                            st_d.ar = mem_rdata[ADDR_W-1:0];
                            st_d.dr = mem_rdata;
                        end
                        st_d.step = ST_T4;
                    end
                end
                ST_T4: begin
                    unique case (dec.opc)
                        OP_AND, OP_ADD, OP_LDA: begin
                            st_d.ac = mem_res;
                            st_d.dr = mem_rdata;
                        end
                        OP_STA: begin
                            st_d.dr = st_q.ac;
                            we_d    = 1'b1;
                        end
                        OP_BUN: begin
                            st_d.pc = st_q.ar;
                        end
                        default: begin
                        end
                    endcase
                    st_d.step = ST_T0;
                end
                default: begin
                    st_d.step = ST_T0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_d.ar;
    assign mem_wdata = st_d.dr;
    assign mem_we    = we_d;
    assign pc_o      = st_q.pc;
    assign ir_o      = st_q.ir;
    assign ar_o      = st_q.ar;
    assign ac_o      = st_q.ac;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
    import acc_seq_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input step_e step_i,
    input logic  halted_i,
    input addr_t pc_i,
    input addr_t ar_i,
    input word_t ir_i,
    input word_t ac_i,
    input logic  we_i,
    input word_t rdata_i
);

    logic [OPC_W-1:0] opc;
    assign opc = ir_i[OPC_LSB +: OPC_W];

    p_fetch_ar_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i == ST_T0 && !halted_i) |=> (ar_i == $past(pc_i)));

    p_fetch_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i == ST_T1 && !halted_i) |=> (pc_i == $past(pc_i) + 1'b1));

    p_direct_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i == ST_T3 && !halted_i && opc != 3'd7 && !ir_i[MODE_BIT])
        |=> ($stable(ar_i) && step_i == ST_T4));

    p_indirect_ar_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i == ST_T3 && !halted_i && opc != 3'd7 && ir_i[MODE_BIT])
        |=> (ar_i == $past(rdata_i[ADDR_W-1:0])));

    p_we_only_store_r6: assert property (@(posedge clk) disable iff (rst)
        we_i |-> (step_i == ST_T4 && opc == 3'd3 && !halted_i));

    p_branch_pc_r7: assert property (@(posedge clk) disable iff (rst)
        (step_i == ST_T4 && opc == 3'd4 && !halted_i) |=> (pc_i == $past(ar_i)));

    p_reg_four_r8: assert property (@(posedge clk) disable iff (rst)
        (step_i == ST_T3 && opc == 3'd7 && !halted_i) |=> (step_i == ST_T0 && !we_i));

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted_i |=> (halted_i && $stable(pc_i) && $stable(ar_i)
                      && $stable(ir_i) && $stable(ac_i) && !we_i));

endmodule

bind acc_seq_top acc_seq_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .step_i   (st_q.step),
    .halted_i (st_q.halted),
    .pc_i     (st_q.pc),
    .ar_i     (st_q.ar),
    .ir_i     (st_q.ir),
    .ac_i     (st_q.ac),
    .we_i     (mem_we),
    .rdata_i  (mem_rdata)
);

// File: tb/test_acc_seq_top.sv
`timescale 1ns/1ps
module test_acc_seq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [11:0] pc_o;
    logic [15:0] ir_o;
    logic [11:0] ar_o;
    logic [15:0] ac_o;

    acc_seq_top i_acc_seq_top (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .pc_o      (pc_o),
        .ir_o      (ir_o),
        .ar_o      (ar_o),
        .ac_o      (ac_o)
    );

    always #2.5 clk = ~clk;

    // bench memory: registered read, one cycle latency
    logic [15:0] ram [0:4095];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    // reference model state
    logic [15:0] m_mem [0:4095];
    logic [11:0] m_pc, m_ar;
    logic [15:0] m_ir, m_ac;
    logic        m_we, m_halt;
    int          vectors = 0;
    int          bad     = 0;
    bit          done    = 0;

    function automatic logic [15:0] mk(input logic ind, input logic [2:0] op,
                                       input logic [11:0] a);
        return {ind, op, a};
    endfunction

    task automatic put(input logic [11:0] a, input logic [15:0] w);
        ram[a]   = w;
        m_mem[a] = w;
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (pc_o !== m_pc || ar_o !== m_ar || ir_o !== m_ir || ac_o !== m_ac
            || mem_we !== m_we || (m_we && mem_wdata !== m_ac)) begin
            bad++;
            $display("FAIL %s t=%0t act pc=%h ar=%h ir=%h ac=%h we=%b wd=%h exp pc=%h ar=%h ir=%h ac=%h we=%b wd=%h",
                     tag, $time, pc_o, ar_o, ir_o, ac_o, mem_we, mem_wdata,
                     m_pc, m_ar, m_ir, m_ac, m_we, m_ac);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        compare(tag);
    endtask

    // one instruction, one expected state per clock
    task automatic exec_one();
        logic [15:0] w;
        logic        ind;
        logic [2:0]  op;
        logic [11:0] a;
        string       tag;
        w   = m_mem[m_pc];
        ind = w[15];
        op  = w[14:12];
        a   = w[11:0];
        m_we = 1'b0;
        m_ar = m_pc;                 tick("R2");
        m_ir = w; m_pc = m_pc + 1'b1; tick("R2");
        if (op == 3'd7) begin
            tick("R8");
            if (w[3]) m_ac = 16'h0000;
            if (w[2]) m_ac = ~m_ac;
            if (w[1]) m_ac = m_ac + 16'h0001;
            if (w[0]) m_halt = 1'b1;
            tick(w[0] ? "R9" : "R8");
            return;
        end
        case (op)
            3'd0, 3'd1, 3'd2: tag = "R5";
            3'd3:             tag = "R6";
            3'd4:             tag = "R7";
            default:          tag = "R10";
        endcase
        m_ar = a;
        tick(ind ? "R4" : "R3");
        if (ind) m_ar = m_mem[a][11:0];
        m_we = (op == 3'd3);
        tick(ind ? "R4" : "R3");
        m_we = 1'b0;
        case (op)
            3'd0: m_ac = m_ac & m_mem[m_ar];
            3'd1: m_ac = m_ac + m_mem[m_ar];
            3'd2: m_ac = m_mem[m_ar];
            3'd3: m_mem[m_ar] = m_ac;
            3'd4: m_pc = m_ar;
            default: ;
        endcase
        tick(tag);
    endtask

    task automatic run_to_halt();
        int guard = 0;
        while (!m_halt && guard < 200) begin
            exec_one();
            guard++;
        end
        for (int k = 0; k < 20; k++) tick("R9");
    endtask

    task automatic reset_check();
        m_pc = '0; m_ar = '0; m_ir = '0; m_ac = '0; m_we = 1'b0; m_halt = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1");
        rst = 1'b0;
    endtask

    task automatic check_word(input logic [11:0] a, input logic [15:0] exp, input string tag);
        vectors++;
        if (ram[a] !== exp) begin
            bad++;
            $display("FAIL %s mem[%h] act=%h exp=%h", tag, a, ram[a], exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) put(i[11:0], 16'h0000);
        // program
        put(12'h000, mk(0, 3'd2, 12'h100)); // load 00FF
        put(12'h001, mk(1, 3'd1, 12'h101)); // add via pointer, wraps to 0
        put(12'h002, mk(0, 3'd2, 12'h103));
        put(12'h003, mk(0, 3'd0, 12'h104));
        put(12'h004, mk(0, 3'd3, 12'h105));
        put(12'h005, mk(1, 3'd3, 12'h106));
        put(12'h006, mk(0, 3'd7, 12'h00C)); // clear then complement
        put(12'h007, mk(1, 3'd7, 12'h002)); // increment, mode bit ignored
        put(12'h008, mk(0, 3'd2, 12'h108));
        put(12'h009, mk(0, 3'd7, 12'h006)); // negate
        put(12'h00A, mk(0, 3'd5, 12'h105));
        put(12'h00B, mk(1, 3'd6, 12'h106));
        put(12'h00C, mk(1, 3'd4, 12'h109));
        put(12'h020, mk(0, 3'd1, 12'h10A));
        put(12'h021, mk(0, 3'd4, 12'h030));
        put(12'h030, mk(1, 3'd2, 12'h10B)); // reads the stored word
        put(12'h031, mk(0, 3'd7, 12'h003)); // increment and halt
        // data
        put(12'h100, 16'h00FF);
        put(12'h101, 16'h0102);
        put(12'h102, 16'hFF01);
        put(12'h103, 16'h1234);
        put(12'h104, 16'h0F0F);
        put(12'h106, 16'h0107);
        put(12'h108, 16'h0005);
        put(12'h109, 16'h0020);
        put(12'h10A, 16'h0006);
        put(12'h10B, 16'h0105);

        reset_check();
        run_to_halt();
        check_word(12'h105, 16'h0204, "R6");
        check_word(12'h107, 16'h0204, "R6");
        check_word(12'h100, 16'h00FF, "R6");
        vectors++;
        if (ac_o !== 16'h0205) begin
            bad++;
            $display("FAIL R9 final ac act=%h exp=%h", ac_o, 16'h0205);
        end
        // reset out of the halted state, then run again
        reset_check();
        run_to_halt();
        check_word(12'h105, 16'h0204, "R6");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

endmodule